// File: doc/BRIEF.md
# Egress unicast queue ID resolver

This block turns a packet descriptor into the number of the egress unicast queue the packet is to be placed on. The descriptor supplies a source profile, a service code and a CPU code (each with its own enable), a destination port, an internal priority and a hash value. The block uses these fields to select one entry in a queue base table. That entry yields a base queue and a profile ID. The profile ID, together with the priority and the hash, then selects one entry in each of two offset tables. The resolved queue is the base plus both offsets.

All three tables sit inside the block and are written through one register-style write port. Each write names the target table, an entry index and a data word. Lookups run in a two-stage pipeline that accepts one request per cycle. Configuration code must load the hash offset entries before traffic uses them. This design clears all three tables on reset, so an unconfigured lookup resolves to queue 0.

The base table is split into three equal regions, each holding 2^(SPROF_W+CODE_W) entries. The region chosen for a lookup follows a fixed precedence: the service code wins, then the CPU code, then the destination port.

Top module: `qr_resolver`

## Requirements
- R1: With both code enables low, the base entry index is the source profile × 2^CODE_W plus the destination port, in region 0, which starts at index 0.
- R2: With the CPU code enabled and the service code disabled, the index is 2^(SPROF_W+CODE_W) + source profile × 2^CODE_W + CPU code. The destination port is then ignored.
- R3: With the service code enabled, the index is 2 × 2^(SPROF_W+CODE_W) + source profile × 2^CODE_W + service code. This holds whatever the CPU code enable is.
- R4: In a base entry, bits PID_W-1:0 (3:0 by default) hold the profile ID and bits PID_W+QW-1:PID_W (11:4 by default) hold the queue base. The profile ID is presented on rsp_profile.
- R5: The priority offset is read from entry profile ID × 2^PRI_W + priority. Only the entry's bits POFF_W-1:0 (3:0) are stored.
- R6: The hash offset is read from entry profile ID × 2^HASH_W + hash. Only the entry's bits QW-1:0 (7:0) are stored.
- R7: rsp_queue equals (queue base + priority offset + hash offset) modulo 2^QW.
- R8: rsp_valid rises exactly two cycles after a cycle with req_valid high. Requests may be issued on consecutive cycles, and each one produces its own result.
- R9: wr_sel selects the table: 0 is base, 1 is priority, 2 is hash, and 3 is none. A write whose wr_idx is not below the selected table's depth, or whose wr_sel is 3, changes no entry. Such a write sets wr_err one cycle later. wr_err stays set until reset and is 0 after reset.
- R10: Reset clears every table entry, and rsp_valid is 0 after reset. A lookup made before any write therefore returns queue 0 with profile 0.
- R11: The base entry is read in the request cycle, and both offset entries are read in the following cycle. A write to an entry in the same cycle that the entry is read does not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_sprof | input | SPROF_W (1) | Source profile |
| req_svc_en | input | 1 | Service code enable |
| req_svc | input | CODE_W (8) | Service code |
| req_cpu_en | input | 1 | CPU code enable |
| req_cpu | input | CODE_W (8) | CPU code |
| req_dport | input | CODE_W (8) | Destination port |
| req_pri | input | PRI_W (4) | Internal priority |
| req_hash | input | HASH_W (6) | Hash value |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Target table: 0 base, 1 priority, 2 hash, 3 none |
| wr_idx | input | WIDX_W (12) | Entry index of the write |
| wr_data | input | PID_W+QW (12) | Write data |
| wr_err | output | 1 | Sticky flag set by a rejected write |
| rsp_valid | output | 1 | Result present |
| rsp_queue | output | QW (8) | Resolved unicast queue ID |
| rsp_profile | output | PID_W (4) | Profile ID taken from the base entry |

## Verification
The bench uses the default parameters: one source-profile bit, 8-bit codes, 4-bit profile IDs and priorities, and a 6-bit hash. This gives tables of 1536, 256 and 1024 entries. With 12-bit write indices, several out-of-range indices fold onto live entries when truncated to a table's own address width. A missing range check therefore shows up as a changed lookup result. The region widths allow a service-code, CPU-code and port entry to be loaded for the same descriptor, which exercises the precedence. 8-bit queue bases make the sum wrap.

// File: rtl/qr_pkg.sv
// Shared types and helpers for the unicast queue resolver.
// Assumes: three tables addressed by a 2-bit select code.
package qr_pkg;

    typedef enum logic [1:0] {
        TS_BASE = 2'd0,
        TS_PRIO = 2'd1,
        TS_HASH = 2'd2,
        TS_NONE = 2'd3
    } tsel_e;

    typedef enum logic [1:0] {
        RG_PORT = 2'd0,
        RG_CPU  = 2'd1,
        RG_SVC  = 2'd2
    } region_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/qr_index_sel.sv
// Base-table index selector: picks a region by fixed precedence
// (service code, then CPU code, then destination port) and appends
// the source profile and the selected code.
// Assumes: the region size is a power of two, so the index is a concatenation.
module qr_index_sel
    import qr_pkg::*;
#(
    parameter int SPROF_W = 1,
    parameter int CODE_W  = 8,
    localparam int IW     = SPROF_W + CODE_W + 2
) (
    input  logic [SPROF_W-1:0] sprof,
    input  logic               svc_en,
    input  logic [CODE_W-1:0]  svc,
    input  logic               cpu_en,
    input  logic [CODE_W-1:0]  cpu,
    input  logic [CODE_W-1:0]  dport,
    output logic [IW-1:0]      idx
);

    region_e             region;
    logic [CODE_W-1:0]   code;

    // Precedence choice of region and code.
    always_comb begin
        if (svc_en) begin
            region = RG_SVC;
            code   = svc;
        end else if (cpu_en) begin
            region = RG_CPU;
            code   = cpu;
        end else begin
            region = RG_PORT;
            code   = dport;
        end
        idx = {region, sprof, code};
    end

endmodule

// File: rtl/qr_table.sv
// Single-write-port lookup table with an asynchronous read.
// It is cleared to zero on synchronous reset.
// Assumes: the reader only presents addresses below DEPTH.
// A write in the same cycle as a read is seen only after the edge.
module qr_table #(
    parameter int DEPTH   = 256,
    parameter int WIDTH   = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Clear on reset, otherwise commit one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qr_wr_decode.sv
// Write-port decoder: routes a write to one table when its index is
// inside that table's depth, and holds a sticky error for rejected writes.
// Assumes: select code 3 targets no table.
module qr_wr_decode
    import qr_pkg::*;
#(
    parameter int WIDX_W     = 12,
    parameter int DEPTH_BASE = 1536,
    parameter int DEPTH_PRIO = 256,
    parameter int DEPTH_HASH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WIDX_W-1:0] wr_idx,
    output logic              we_base,
    output logic              we_prio,
    output logic              we_hash,
    output logic              err
);

    localparam logic [WIDX_W-1:0] LIM_B = WIDX_W'(DEPTH_BASE);
    localparam logic [WIDX_W-1:0] LIM_P = WIDX_W'(DEPTH_PRIO);
    localparam logic [WIDX_W-1:0] LIM_H = WIDX_W'(DEPTH_HASH);

    logic accept;

    // Per-table range test and strobe generation.
    always_comb begin
        we_base = 1'b0;
        we_prio = 1'b0;
        we_hash = 1'b0;
        unique case (tsel_e'(wr_sel))
            TS_BASE: we_base = wr_en && (wr_idx < LIM_B);
            TS_PRIO: we_prio = wr_en && (wr_idx < LIM_P);
            TS_HASH: we_hash = wr_en && (wr_idx < LIM_H);
            default: ;
        endcase
        accept = we_base | we_prio | we_hash;
    end

    // Sticky flag for any write that was rejected.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (wr_en && !accept)  err <= 1'b1;
    end

endmodule

// File: rtl/qr_resolver.sv
// Egress unicast queue resolver, top level. Stage 1 reads the base table at
// the precedence-selected index. Stage 2 reads the priority and hash offset
// tables with the profile ID from stage 1 and registers the wrapped sum.
// Assumes: base region size 2^(SPROF_W+CODE_W) with three regions.
module qr_resolver
    import qr_pkg::*;
#(
    parameter int SPROF_W   = 1,
    parameter int CODE_W    = 8,
    parameter int PID_W     = 4,
    parameter int PRI_W     = 4,
    parameter int HASH_W    = 6,
    parameter int QW        = 8,
    parameter int POFF_W    = 4,
    localparam int DW         = PID_W + QW,
    localparam int DEPTH_BASE = 3 * (1 << (SPROF_W + CODE_W)),
    localparam int DEPTH_PRIO = 1 << (PID_W + PRI_W),
    localparam int DEPTH_HASH = 1 << (PID_W + HASH_W),
    localparam int WIDX_W     = $clog2(max3(DEPTH_BASE, DEPTH_PRIO, DEPTH_HASH)) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SPROF_W-1:0] req_sprof,
    input  logic               req_svc_en,
    input  logic [CODE_W-1:0]  req_svc,
    input  logic               req_cpu_en,
    input  logic [CODE_W-1:0]  req_cpu,
    input  logic [CODE_W-1:0]  req_dport,
    input  logic [PRI_W-1:0]   req_pri,
    input  logic [HASH_W-1:0]  req_hash,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WIDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic               wr_err,
    output logic               rsp_valid,
    output logic [QW-1:0]      rsp_queue,
    output logic [PID_W-1:0]   rsp_profile
);

    localparam int BAW = $clog2(DEPTH_BASE);
    localparam int PAW = PID_W + PRI_W;
    localparam int HAW = PID_W + HASH_W;

    logic              we_base, we_prio, we_hash;
    logic [BAW-1:0]    base_idx;
    logic [DW-1:0]     base_entry;
    logic [POFF_W-1:0] prio_off;
    logic [QW-1:0]     hash_off;

    logic              s1_valid;
    logic [QW-1:0]     s1_base;
    logic [PID_W-1:0]  s1_pid;
    logic [PRI_W-1:0]  s1_pri;
    logic [HASH_W-1:0] s1_hash;

    qr_wr_decode #(
        .WIDX_W(WIDX_W), .DEPTH_BASE(DEPTH_BASE),
        .DEPTH_PRIO(DEPTH_PRIO), .DEPTH_HASH(DEPTH_HASH)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .we_base(we_base), .we_prio(we_prio),
        .we_hash(we_hash), .err(wr_err)
    );

    qr_index_sel #(.SPROF_W(SPROF_W), .CODE_W(CODE_W)) u_sel (
        .sprof(req_sprof), .svc_en(req_svc_en), .svc(req_svc),
        .cpu_en(req_cpu_en), .cpu(req_cpu), .dport(req_dport),
        .idx(base_idx)
    );

    qr_table #(.DEPTH(DEPTH_BASE), .WIDTH(DW)) u_base (
        .clk(clk), .rst_n(rst_n), .we(we_base),
        .waddr(wr_idx[BAW-1:0]), .wdata(wr_data),
        .raddr(base_idx), .rdata(base_entry)
    );

    qr_table #(.DEPTH(DEPTH_PRIO), .WIDTH(POFF_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .we(we_prio),
        .waddr(wr_idx[PAW-1:0]), .wdata(wr_data[POFF_W-1:0]),
        .raddr({s1_pid, s1_pri}), .rdata(prio_off)
    );

    qr_table #(.DEPTH(DEPTH_HASH), .WIDTH(QW)) u_hash (
        .clk(clk), .rst_n(rst_n), .we(we_hash),
        .waddr(wr_idx[HAW-1:0]), .wdata(wr_data[QW-1:0]),
        .raddr({s1_pid, s1_hash}), .rdata(hash_off)
    );

    // Stage 1: capture the base entry fields and the offset keys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_base  <= '0;
            s1_pid   <= '0;
            s1_pri   <= '0;
            s1_hash  <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_base  <= base_entry[DW-1:PID_W];
            s1_pid   <= base_entry[PID_W-1:0];
            s1_pri   <= req_pri;
            s1_hash  <= req_hash;
        end
    end

    // Stage 2: add both offsets with wrap and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_queue   <= '0;
            rsp_profile <= '0;
        end else begin
            rsp_valid   <= s1_valid;
            rsp_queue   <= s1_base + QW'(prio_off) + hash_off;
            rsp_profile <= s1_pid;
        end
    end

endmodule

// File: rtl/qr_resolver_chk.sv
// Property checker for qr_resolver: pipeline timing and write-error behaviour.
// Assumes: it is attached to every qr_resolver instance through the bind below.
module qr_resolver_chk #(
    parameter int WIDX_W     = 12,
    parameter int DEPTH_BASE = 1536,
    parameter int DEPTH_PRIO = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WIDX_W-1:0] wr_idx,
    input logic              wr_err,
    input logic              rsp_valid
);

    logic [1:0] age;

    // Count the cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

    p_no_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd2) |-> !rsp_valid);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    p_err_nosel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> wr_err);

    p_err_base_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_idx >= WIDX_W'(DEPTH_BASE)) |=> wr_err);

    p_err_good_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_err && wr_en && wr_sel == 2'd1 && wr_idx < WIDX_W'(DEPTH_PRIO)) |=> !wr_err);

    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> !wr_err);

endmodule

bind qr_resolver qr_resolver_chk #(
    .WIDX_W(WIDX_W), .DEPTH_BASE(DEPTH_BASE), .DEPTH_PRIO(DEPTH_PRIO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_err(wr_err), .rsp_valid(rsp_valid)
);

// File: tb/sim_qr_resolver.sv
`timescale 1ns/1ps
// Bench for qr_resolver: a behavioural model of the tables and the two-cycle
// latency, compared with the outputs on every clock.
module sim_qr_resolver;

    localparam int SPW  = 1;
    localparam int CW   = 8;
    localparam int HW   = 6;
    localparam int RGN  = 1 << (SPW + CW);
    localparam int DB   = 3 * RGN;
    localparam int DP   = 256;
    localparam int DH   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_sprof = '0;
    logic        req_svc_en = 1'b0;
    logic [7:0]  req_svc = '0;
    logic        req_cpu_en = 1'b0;
    logic [7:0]  req_cpu = '0;
    logic [7:0]  req_dport = '0;
    logic [3:0]  req_pri = '0;
    logic [5:0]  req_hash = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [11:0] wr_idx = '0;
    logic [11:0] wr_data = '0;
    logic        wr_err;
    logic        rsp_valid;
    logic [7:0]  rsp_queue;
    logic [3:0]  rsp_profile;

    always #4 clk = ~clk;

    qr_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sprof(req_sprof),
        .req_svc_en(req_svc_en), .req_svc(req_svc), .req_cpu_en(req_cpu_en),
        .req_cpu(req_cpu), .req_dport(req_dport), .req_pri(req_pri),
        .req_hash(req_hash), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(wr_err), .rsp_valid(rsp_valid),
        .rsp_queue(rsp_queue), .rsp_profile(rsp_profile)
    );

    int mbase [DB];
    int mprio [DP];
    int mhash [DH];
    int s1v = 0, s1b = 0, s1p = 0, s1pri = 0, s1h = 0;
    int ev = 0, eq = 0, ep = 0, eerr = 0;
    int checks = 0, fails = 0;
    string cur = "R10";
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: advance the model with the tables as they stood before the
    // edge, apply the write, then compare after the edge.
    task automatic tick();
        int nv, nq, np, idx, e, rg, code;
        nv = s1v; nq = eq; np = ep;
        if (s1v != 0) begin
            np = s1p;
            nq = (s1b + mprio[s1p * 16 + s1pri] + mhash[s1p * 64 + s1h]) % 256;
        end
        if (req_valid) begin
            if (req_svc_en)      begin rg = 2; code = int'(req_svc); end
            else if (req_cpu_en) begin rg = 1; code = int'(req_cpu); end
            else                 begin rg = 0; code = int'(req_dport); end
            idx = rg * RGN + int'(req_sprof) * 256 + code;
            e = mbase[idx];
            s1b = (e >> 4) & 255;
            s1p = e & 15;
            s1pri = int'(req_pri);
            s1h = int'(req_hash);
        end
        s1v = req_valid ? 1 : 0;
        if (wr_en) begin
            if (wr_sel == 2'd0 && int'(wr_idx) < DB)      mbase[wr_idx] = int'(wr_data);
            else if (wr_sel == 2'd1 && int'(wr_idx) < DP) mprio[wr_idx] = int'(wr_data) & 15;
            else if (wr_sel == 2'd2 && int'(wr_idx) < DH) mhash[wr_idx] = int'(wr_data) & 255;
            else eerr = 1;
        end
        ev = nv; eq = nq; ep = np;
        @(posedge clk);
        @(negedge clk);
        chk(int'(rsp_valid) == ev, "R8 rsp_valid", int'(rsp_valid), ev);
        if (ev != 0) begin
            chk(int'(rsp_queue) == eq, {cur, " rsp_queue"}, int'(rsp_queue), eq);
            chk(int'(rsp_profile) == ep, "R4 rsp_profile", int'(rsp_profile), ep);
        end
        chk(int'(wr_err) == eerr, "R9 wr_err", int'(wr_err), eerr);
        req_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic set_req(int sp, bit se, int sv, bit ce, int cv, int dp, int pr, int hs);
        req_valid = 1'b1; req_sprof = 1'(sp);
        req_svc_en = se; req_svc = 8'(sv);
        req_cpu_en = ce; req_cpu = 8'(cv);
        req_dport = 8'(dp); req_pri = 4'(pr); req_hash = 6'(hs);
    endtask

    task automatic set_wr(int sel, int idx, int data);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_idx = 12'(idx); wr_data = 12'(data);
    endtask

    task automatic wr(int sel, int idx, int data);
        set_wr(sel, idx, data);
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk(rsp_valid == 1'b0, "R10 reset rsp_valid", int'(rsp_valid), 0);
        chk(rsp_queue == 8'd0, "R10 reset rsp_queue", int'(rsp_queue), 0);
        chk(wr_err == 1'b0, "R9 reset wr_err", int'(wr_err), 0);

        // R10: unconfigured lookup gives queue 0
        cur = "R10";
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick(); idle(2);

        // R1: destination port region, two source profiles
        cur = "R1";
        wr(0, 5, (20 << 4) | 3);
        wr(1, 3 * 16 + 2, 4);
        wr(2, 3 * 64 + 7, 9);
        wr(0, 256 + 5, (40 << 4) | 1);
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick();
        set_req(1, 0, 0, 0, 0, 5, 2, 7); tick(); idle(2);

        // R2: CPU code wins over the destination port
        cur = "R2";
        wr(0, RGN + 101, (60 << 4) | 2);
        set_req(0, 0, 0, 1, 101, 5, 2, 7); tick(); idle(2);

        // R3: service code wins over the CPU code
        cur = "R3";
        wr(0, 2 * RGN + 256 + 9, (100 << 4) | 5);
        set_req(1, 1, 9, 1, 101, 5, 0, 0); tick(); idle(2);

        // R5: priority offset, upper data bits dropped
        cur = "R5";
        wr(1, 5 * 16 + 15, 12'h0F7);
        set_req(1, 1, 9, 0, 0, 0, 15, 0); tick(); idle(2);

        // R6 and R7: hash offset keeps bits 7:0, the sum wraps past 255
        cur = "R7";
        wr(2, 5 * 64 + 63, 12'h1AB);
        set_req(1, 1, 9, 0, 0, 0, 15, 63); tick(); idle(2);
        cur = "R6";
        wr(2, 2 * 64 + 1, 200);
        set_req(0, 0, 0, 1, 101, 0, 0, 1); tick(); idle(2);

        // R8: back-to-back requests
        cur = "R8";
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick();
        set_req(1, 0, 0, 0, 0, 5, 2, 7); tick();
        set_req(0, 0, 0, 1, 101, 5, 0, 1); tick();
        set_req(1, 1, 9, 0, 0, 0, 15, 63); tick();
        idle(3);

        // R9: rejected writes leave entries alone, including on truncation
        cur = "R9";
        wr(2, 1024 + 3 * 64 + 7, 12'h055);
        wr(1, 256 + 3 * 16 + 2, 12'h00E);
        wr(0, DB, 12'hFFF);
        wr(3, 5, 12'h123);
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick(); idle(2);

        // R11: a write in the same cycle as the read does not affect that lookup
        cur = "R11";
        set_req(0, 0, 0, 0, 0, 5, 2, 7);
        set_wr(0, 5, (70 << 4) | 3);
        tick(); idle(2);
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick();
        wr(1, 3 * 16 + 2, 1);
        idle(2);
        set_req(0, 0, 0, 0, 0, 5, 2, 7); tick(); idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule